// File: doc/BRIEF.md
# Bus Address Comparator Trigger Unit

This block watches a processor bus with two programmable comparators, A and B, and decides when a debug trigger fires. A 4-bit mode selects how the two comparator results combine: single address, either address, a two-step sequence, address ranges, address-plus-data, or event-only modes in which each B hit is recorded on its own. A trigger-type bit picks between firing on the bus access itself (force) and firing only once the matched opcode is confirmed as executed (tag).

The unit drives an external trace buffer through a per-cycle store enable. In end-trace style it stores every bus cycle while armed and stops at the trigger. In begin-trace style it stores nothing until the trigger and then stores a fixed number of bus cycles. The trigger register may be written only while the unit is disarmed. Arming the unit from the disarmed state clears all run state.

Top module: `bus_trig_unit`

## Requirements
- R1: After reset the trigger register reads 0x00, and storeEn, statTrig, statDone and statArmed are all 0.
- R2: The trigger register holds the tag bit at bit 7, the begin bit at bit 6 and the mode at bits 3:0. Bits 5:4 always read 0. A write while armed leaves the register unchanged.
- R3: Mode 0 fires on an access to address A. Mode 1 fires on an access to A or B. Mode 7 fires when A <= addr <= B. Mode 8 fires when addr < A or addr > B. All comparisons are unsigned.
- R4: Mode 2 fires on a B access only after an earlier A access in the same armed run. The A-seen flag is cleared when the unit is re-armed.
- R5: Mode 5 fires when the address equals A and the data equals the low data byte of B. Mode 6 fires when the address equals A and the data differs from that byte.
- R6: Mode codes 9 to 15 never set statTrig.
- R7: With the tag bit set, only an opcode-fetch access records a match, holding the newest fetch address. The trigger fires in the cycle in which execValid reports that same address. A flush discards the recorded match.
- R8: End trace (begin bit 0): storeEn is high on every valid bus cycle while armed and not yet triggered, including the trigger cycle. From the next cycle statTrig and statDone are 1 and storeEn stays 0.
- R9: Begin trace (begin bit 1): storeEn is 0 up to and including the trigger cycle. It is then high on exactly STORE_DEPTH valid bus cycles, after which statDone rises.
- R10: Event-only modes 3 (each B access) and 4 (each B access after an A access) ignore the begin bit. They raise storeEn exactly in each qualifying cycle, set statTrig on the first one, and never set statDone.
- R11: Writing 0 to the arm bit forces storeEn to 0 from the next cycle on, and statArmed reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigWrEn | input | 1 | Write strobe for the trigger register |
| trigWrData | input | 8 | Trigger register write value |
| trigRdData | output | 8 | Trigger register read value |
| armWrEn | input | 1 | Write strobe for the arm bit |
| armWrData | input | 1 | New arm bit value |
| cmpA | input | ADDR_W | Comparator A address |
| cmpB | input | ADDR_W | Comparator B address (low byte also used as the data compare value) |
| busValid | input | 1 | A bus access occurs this cycle |
| busAddr | input | ADDR_W | Bus access address |
| busData | input | DATA_W | Bus access data |
| busFetch | input | 1 | The access is an opcode fetch |
| execValid | input | 1 | An opcode completes execution this cycle |
| execAddr | input | ADDR_W | Address of the executed opcode |
| flush | input | 1 | Pipeline flush; drops any recorded tag match |
| storeEn | output | 1 | Store the current bus cycle into the trace buffer |
| statTrig | output | 1 | A trigger has occurred in this run |
| statDone | output | 1 | Capture has completed |
| statArmed | output | 1 | Current arm bit |

## Verification
The assertions assume that the comparator values stay constant while the unit is armed, and that execAddr is only looked at when execValid is high. They also assume the trigger mode cannot change within a run, because writes are blocked while armed. The stimulus sets cmpA and cmpB once before the first arming and never changes them. It changes the trigger register only between runs, except for one deliberate write while armed that tests the lock. It raises execValid and flush only in isolated cycles of the tag scenario.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam logic [3:0] MODE_A_ONLY    = 4'd0;
  localparam logic [3:0] MODE_A_OR_B    = 4'd1;
  localparam logic [3:0] MODE_A_THEN_B  = 4'd2;
  localparam logic [3:0] MODE_EVT_B     = 4'd3;
  localparam logic [3:0] MODE_A_EVT_B   = 4'd4;
  localparam logic [3:0] MODE_A_DATA_EQ = 4'd5;
  localparam logic [3:0] MODE_A_DATA_NE = 4'd6;
  localparam logic [3:0] MODE_IN_RANGE  = 4'd7;
  localparam logic [3:0] MODE_OUT_RANGE = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic       armed;
    logic       clrRun;
    logic       tagSel;
    logic [3:0] mode;
  } ctlStrobe_t;

endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] cmpA,
  input  logic [ADDR_W-1:0] cmpB,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busFetch,
  input  logic              execValid,
  input  logic [ADDR_W-1:0] execAddr,
  input  logic              flush,
  output logic              fire
);

  logic              aHit, bHit, dHit, inRange, seqMode;
  logic              seqSeen;
  logic              modeEvent;
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic              record, confirm;

  assign aHit    = (busAddr == cmpA);
  assign bHit    = (busAddr == cmpB);
  assign dHit    = (busData == cmpB[DATA_W-1:0]);
  assign inRange = (busAddr >= cmpA) && (busAddr <= cmpB);
  assign seqMode = (ctl.mode == MODE_A_THEN_B) || (ctl.mode == MODE_A_EVT_B);

  always_comb begin
    case (ctl.mode)
      MODE_A_ONLY:    modeEvent = aHit;
      MODE_A_OR_B:    modeEvent = aHit | bHit;
      MODE_A_THEN_B:  modeEvent = seqSeen & bHit;
      MODE_EVT_B:     modeEvent = bHit;
      MODE_A_EVT_B:   modeEvent = seqSeen & bHit;
      MODE_A_DATA_EQ: modeEvent = aHit & dHit;
      MODE_A_DATA_NE: modeEvent = aHit & ~dHit;
      MODE_IN_RANGE:  modeEvent = inRange;
      MODE_OUT_RANGE: modeEvent = ~inRange;
      default:        modeEvent = 1'b0;
    endcase
  end

  // sequential A-seen flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          seqSeen <= 1'b0;
    else if (ctl.clrRun)                                seqSeen <= 1'b0;
    else if (ctl.armed && busValid && aHit && seqMode)  seqSeen <= 1'b1;
  end

  // tag tracking: newest matching fetch waits for execute confirmation
  assign record  = ctl.armed && ctl.tagSel && busValid && busFetch && modeEvent;
  assign confirm = pendValid && execValid && (execAddr == pendAddr) && !flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
    end else if (ctl.clrRun) begin
      pendValid <= 1'b0;
    end else if (record) begin
      pendValid <= 1'b1;
      pendAddr  <= busAddr;
    end else if (flush || confirm) begin
      pendValid <= 1'b0;
    end
  end

  always_comb begin
    if (!ctl.armed)     fire = 1'b0;
    else if (ctl.tagSel) fire = confirm;
    else                fire = busValid && modeEvent;
  end

endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
#(
  parameter int STORE_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigWrEn,
  input  logic [7:0] trigWrData,
  output logic [7:0] trigRdData,
  input  logic       armWrEn,
  input  logic       armWrData,
  input  logic       busValid,
  input  logic       fire,
  output ctlStrobe_t ctl,
  output logic       storeEn,
  output logic       statTrig,
  output logic       statDone,
  output logic       statArmed
);

  localparam int CNT_W = (STORE_DEPTH > 1) ? $clog2(STORE_DEPTH) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STORE_DEPTH - 1);

  logic             armReg, tagReg, beginReg;
  logic [3:0]       modeReg;
  logic             trigd, done;
  logic [CNT_W-1:0] storeCnt;
  logic             clrRun, isEvent;

  assign clrRun  = armWrEn && armWrData && !armReg;
  assign isEvent = (modeReg == MODE_EVT_B) || (modeReg == MODE_A_EVT_B);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armReg   <= 1'b0;
      tagReg   <= 1'b0;
      beginReg <= 1'b0;
      modeReg  <= '0;
    end else begin
      if (armWrEn) armReg <= armWrData;
      if (trigWrEn && !armReg) begin
        tagReg   <= trigWrData[7];
        beginReg <= trigWrData[6];
        modeReg  <= trigWrData[3:0];
      end
    end
  end

  always_comb begin
    if (!armReg)       storeEn = 1'b0;
    else if (isEvent)  storeEn = fire;
    else if (beginReg) storeEn = busValid && trigd && !done;
    else               storeEn = busValid && !trigd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigd    <= 1'b0;
      done     <= 1'b0;
      storeCnt <= '0;
    end else if (clrRun) begin
      trigd    <= 1'b0;
      done     <= 1'b0;
      storeCnt <= '0;
    end else if (armReg) begin
      if (isEvent) begin
        if (fire) trigd <= 1'b1;
      end else if (!trigd) begin
        if (fire) begin
          trigd <= 1'b1;
          if (!beginReg) done <= 1'b1;
        end
      end else if (storeEn && beginReg) begin
        storeCnt <= storeCnt + 1'b1;
        if (storeCnt == LAST_CNT) done <= 1'b1;
      end
    end
  end

  assign ctl.armed  = armReg;
  assign ctl.clrRun = clrRun;
  assign ctl.tagSel = tagReg;
  assign ctl.mode   = modeReg;

  assign trigRdData = {tagReg, beginReg, 2'b00, modeReg};
  assign statTrig   = trigd;
  assign statDone   = done;
  assign statArmed  = armReg;

endmodule

// File: rtl/bus_trig_unit.sv
module bus_trig_unit
  import trig_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int STORE_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigWrEn,
  input  logic [7:0]        trigWrData,
  output logic [7:0]        trigRdData,
  input  logic              armWrEn,
  input  logic              armWrData,
  input  logic [ADDR_W-1:0] cmpA,
  input  logic [ADDR_W-1:0] cmpB,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busFetch,
  input  logic              execValid,
  input  logic [ADDR_W-1:0] execAddr,
  input  logic              flush,
  output logic              storeEn,
  output logic              statTrig,
  output logic              statDone,
  output logic              statArmed
);

  ctlStrobe_t ctl;
  logic       fire;

  trig_control #(.STORE_DEPTH(STORE_DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN),
    .trigWrEn(trigWrEn), .trigWrData(trigWrData), .trigRdData(trigRdData),
    .armWrEn(armWrEn), .armWrData(armWrData),
    .busValid(busValid), .fire(fire), .ctl(ctl),
    .storeEn(storeEn), .statTrig(statTrig), .statDone(statDone),
    .statArmed(statArmed)
  );

  trig_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cmpA(cmpA), .cmpB(cmpB),
    .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .busFetch(busFetch), .execValid(execValid), .execAddr(execAddr),
    .flush(flush), .fire(fire)
  );

endmodule

// File: rtl/bus_trig_unit_checker.sv
module bus_trig_unit_checker (
  input logic       clk,
  input logic       rstN,
  input logic       trigWrEn,
  input logic [7:0] trigRdData,
  input logic       storeEn,
  input logic       statTrig,
  input logic       statDone,
  input logic       statArmed
);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    trigRdData[5:4] == 2'b00);

  a_r2_write_locked: assert property (@(posedge clk) disable iff (!rstN)
    (statArmed && trigWrEn) |=> $stable(trigRdData));

  a_r6_no_trigger_code: assert property (@(posedge clk) disable iff (!rstN)
    (statArmed && trigRdData[3:0] > 4'd8 && !statTrig) |=> !statTrig);

  a_r8_done_blocks_store: assert property (@(posedge clk) disable iff (!rstN)
    statDone |-> !storeEn);

  a_r9_done_needs_trigger: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statDone) |-> statTrig);

  a_r10_event_never_done: assert property (@(posedge clk) disable iff (!rstN)
    (statArmed && (trigRdData[3:0] == 4'd3 || trigRdData[3:0] == 4'd4)) |-> !statDone);

  a_r11_disarmed_no_store: assert property (@(posedge clk) disable iff (!rstN)
    !statArmed |-> !storeEn);

endmodule

bind bus_trig_unit bus_trig_unit_checker u_checker (
  .clk(clk), .rstN(rstN), .trigWrEn(trigWrEn), .trigRdData(trigRdData),
  .storeEn(storeEn), .statTrig(statTrig), .statDone(statDone),
  .statArmed(statArmed)
);

// File: tb/test_bus_trig_unit.sv
module test_bus_trig_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigWrEn = 1'b0;
  logic [7:0]  trigWrData = '0;
  logic [7:0]  trigRdData;
  logic        armWrEn = 1'b0;
  logic        armWrData = 1'b0;
  logic [15:0] cmpA = 16'h1000;
  logic [15:0] cmpB = 16'h1010;
  logic        busValid = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busData = '0;
  logic        busFetch = 1'b0;
  logic        execValid = 1'b0;
  logic [15:0] execAddr = '0;
  logic        flush = 1'b0;
  logic        storeEn, statTrig, statDone, statArmed;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  bit    expStoreQ[$];
  string expTagQ[$];

  always #2 clk = ~clk;

  bus_trig_unit #(.ADDR_W(16), .DATA_W(8), .STORE_DEPTH(4)) i_bus_trig_unit (
    .clk(clk), .rstN(rstN),
    .trigWrEn(trigWrEn), .trigWrData(trigWrData), .trigRdData(trigRdData),
    .armWrEn(armWrEn), .armWrData(armWrData),
    .cmpA(cmpA), .cmpB(cmpB),
    .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .busFetch(busFetch), .execValid(execValid), .execAddr(execAddr),
    .flush(flush), .storeEn(storeEn), .statTrig(statTrig),
    .statDone(statDone), .statArmed(statArmed)
  );

  // monitor: compares storeEn against the scoreboard each cycle
  always @(negedge clk) begin
    if (expStoreQ.size() > 0) begin
      bit    e;
      string t;
      e = expStoreQ.pop_front();
      t = expTagQ.pop_front();
      total++;
      if (storeEn !== e) begin
        bad++;
        $display("FAIL %s storeEn actual=%0b expected=%0b", t, storeEn, e);
      end
    end
  end

  task automatic quietBus();
    busValid = 1'b0; busFetch = 1'b0; execValid = 1'b0; flush = 1'b0;
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic [7:0] d,
                      input logic f, input logic ev, input logic [15:0] ea,
                      input logic fl, input bit exp, input string tag);
    @(posedge clk); #1;
    trigWrEn = 1'b0; armWrEn = 1'b0;
    busValid = v; busAddr = a; busData = d; busFetch = f;
    execValid = ev; execAddr = ea; flush = fl;
    expStoreQ.push_back(exp);
    expTagQ.push_back(tag);
  endtask

  task automatic acc(input logic [15:0] a, input logic [7:0] d, input bit exp, input string tag);
    step(1'b1, a, d, 1'b0, 1'b0, 16'h0, 1'b0, exp, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic writeTrig(input logic [7:0] v);
    @(posedge clk); #1;
    quietBus(); armWrEn = 1'b0; trigWrEn = 1'b1; trigWrData = v;
    @(posedge clk); #1;
    trigWrEn = 1'b0;
  endtask

  task automatic setArm(input logic v);
    @(posedge clk); #1;
    quietBus(); trigWrEn = 1'b0; armWrEn = 1'b1; armWrData = v;
    @(posedge clk); #1;
    armWrEn = 1'b0;
  endtask

  task automatic rearm(input logic [7:0] v);
    setArm(1'b0);
    writeTrig(v);
    setArm(1'b1);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    @(negedge clk);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(trigRdData, 8'h00, "R1 trig reg");
    chk({7'd0, storeEn}, 8'h0, "R1 storeEn");
    chk({6'd0, statTrig, statDone}, 8'h0, "R1 status");
    chk({7'd0, statArmed}, 8'h0, "R1 armed");

    // R2 reserved bits and write lock
    writeTrig(8'hFF);
    chk(trigRdData, 8'hCF, "R2 reserved bits read zero");
    writeTrig(8'h01);
    setArm(1'b1);
    writeTrig(8'h47);
    chk(trigRdData, 8'h01, "R2 write while armed ignored");

    // R3 / R8 mode 1 end trace
    acc(16'h0200, 8'h0, 1'b1, "R8 store before trigger");
    acc(16'h0300, 8'h0, 1'b1, "R8 store before trigger");
    idle("R8 no store without bus cycle");
    acc(16'h1010, 8'h0, 1'b1, "R3 R8 trigger cycle stored");
    acc(16'h0200, 8'h0, 1'b0, "R8 stop after trigger");
    chk({6'd0, statTrig, statDone}, 8'h3, "R8 trig and done");

    // R3 / R9 mode 0 begin trace, depth 4
    rearm(8'h40);
    acc(16'h1010, 8'h0, 1'b0, "R3 mode0 ignores B");
    acc(16'h1000, 8'h0, 1'b0, "R9 trigger cycle not stored");
    acc(16'h0500, 8'h0, 1'b1, "R9 store 1");
    idle("R9 gap");
    acc(16'h0504, 8'h0, 1'b1, "R9 store 2");
    acc(16'h0508, 8'h0, 1'b1, "R9 store 3");
    acc(16'h050C, 8'h0, 1'b1, "R9 store 4");
    acc(16'h0510, 8'h0, 1'b0, "R9 depth reached");
    chk({6'd0, statTrig, statDone}, 8'h3, "R9 done after depth");

    // R3 inside range
    rearm(8'h07);
    acc(16'h0FFF, 8'h0, 1'b1, "R3 below range");
    acc(16'h1011, 8'h0, 1'b1, "R3 above range");
    acc(16'h1008, 8'h0, 1'b1, "R3 inside range fires");
    acc(16'h1008, 8'h0, 1'b0, "R3 stop after range trigger");
    chk({7'd0, statTrig}, 8'h1, "R3 range trig");

    // R3 outside range
    rearm(8'h08);
    acc(16'h1000, 8'h0, 1'b1, "R3 boundary A inside");
    acc(16'h1010, 8'h0, 1'b1, "R3 boundary B inside");
    acc(16'h1011, 8'h0, 1'b1, "R3 outside fires");
    acc(16'h0000, 8'h0, 1'b0, "R3 stop after outside trigger");
    chk({7'd0, statTrig}, 8'h1, "R3 outside trig");

    // R4 sequential A then B
    rearm(8'h02);
    acc(16'h1010, 8'h0, 1'b1, "R4 B before A ignored");
    acc(16'h1010, 8'h0, 1'b1, "R4 B before A ignored");
    acc(16'h1000, 8'h0, 1'b1, "R4 A arms sequence");
    acc(16'h0500, 8'h0, 1'b1, "R4 unrelated");
    acc(16'h1010, 8'h0, 1'b1, "R4 B after A fires");
    acc(16'h1010, 8'h0, 1'b0, "R4 stop after trigger");
    chk({7'd0, statTrig}, 8'h1, "R4 trig");
    setArm(1'b0);
    setArm(1'b1);
    acc(16'h1010, 8'h0, 1'b1, "R4 flag cleared by rearm");
    acc(16'h1010, 8'h0, 1'b1, "R4 flag cleared by rearm");
    chk({7'd0, statTrig}, 8'h0, "R4 no trig after rearm");

    // R5 data modes
    rearm(8'h05);
    acc(16'h1000, 8'h11, 1'b1, "R5 data mismatch");
    acc(16'h2000, 8'h10, 1'b1, "R5 address mismatch");
    acc(16'h1000, 8'h10, 1'b1, "R5 A and data fires");
    acc(16'h1000, 8'h10, 1'b0, "R5 stop");
    chk({7'd0, statTrig}, 8'h1, "R5 mode5 trig");
    rearm(8'h06);
    acc(16'h1000, 8'h10, 1'b1, "R5 data equal no fire");
    acc(16'h1000, 8'h33, 1'b1, "R5 A and not data fires");
    acc(16'h1000, 8'h33, 1'b0, "R5 stop");
    chk({7'd0, statTrig}, 8'h1, "R5 mode6 trig");

    // R6 unused codes
    rearm(8'h09);
    acc(16'h1000, 8'h10, 1'b1, "R6 code9 A");
    acc(16'h1010, 8'h10, 1'b1, "R6 code9 B");
    acc(16'h1008, 8'h10, 1'b1, "R6 code9 range");
    chk({7'd0, statTrig}, 8'h0, "R6 code9 no trig");
    rearm(8'h0F);
    acc(16'h1000, 8'h10, 1'b1, "R6 code15 A");
    acc(16'h0000, 8'h10, 1'b1, "R6 code15 outside");
    chk({7'd0, statTrig}, 8'h0, "R6 code15 no trig");

    // R7 tag mode, end trace, mode 1
    rearm(8'h81);
    step(1'b1, 16'h1000, 8'h0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, "R7 fetch recorded");
    step(1'b1, 16'h0400, 8'h0, 1'b1, 1'b1, 16'h0FFF, 1'b0, 1'b1, "R7 other exec");
    step(1'b1, 16'h0404, 8'h0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, "R7 flush");
    step(1'b1, 16'h0408, 8'h0, 1'b0, 1'b1, 16'h1000, 1'b0, 1'b1, "R7 exec after flush");
    step(1'b1, 16'h1010, 8'h0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, "R7 data access not recorded");
    step(1'b1, 16'h040C, 8'h0, 1'b0, 1'b1, 16'h1010, 1'b0, 1'b1, "R7 exec of unfetched");
    chk({7'd0, statTrig}, 8'h0, "R7 no trig before confirm");
    step(1'b1, 16'h1010, 8'h0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, "R7 fetch B");
    step(1'b1, 16'h0410, 8'h0, 1'b0, 1'b1, 16'h1010, 1'b0, 1'b1, "R7 confirm fires");
    acc(16'h0414, 8'h0, 1'b0, "R7 stop after confirm");
    chk({7'd0, statTrig}, 8'h1, "R7 trig after confirm");

    // R10 event-only modes, begin bit ignored
    rearm(8'h03);
    acc(16'h0200, 8'h0, 1'b0, "R10 no store on non-event");
    acc(16'h1010, 8'h0, 1'b1, "R10 B event");
    acc(16'h0200, 8'h0, 1'b0, "R10 no store");
    acc(16'h1010, 8'h0, 1'b1, "R10 B event again");
    idle("R10 idle");
    chk({6'd0, statTrig, statDone}, 8'h2, "R10 trig no done");
    rearm(8'h44);
    acc(16'h1010, 8'h0, 1'b0, "R10 B before A");
    acc(16'h1000, 8'h0, 1'b0, "R10 A");
    acc(16'h1010, 8'h0, 1'b1, "R10 B after A");
    acc(16'h1010, 8'h0, 1'b1, "R10 B after A again");
    chk({6'd0, statTrig, statDone}, 8'h2, "R10 mode4 trig no done");

    // R11 disarm stops storage
    rearm(8'h01);
    acc(16'h0200, 8'h0, 1'b1, "R11 storing while armed");
    setArm(1'b0);
    acc(16'h0204, 8'h0, 1'b0, "R11 no store after disarm");
    chk({7'd0, statArmed}, 8'h0, "R11 armed reads 0");

    idle("end");
    @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule